// File: doc/BRIEF.md
# Fractional-Prescaled Microsecond Counter

This block derives a steady 1 MHz tick from whatever oscillator clocks it and counts those ticks in a free-running counter. The prescaler is rational: software programs a dividend and a divisor, and the block emits ticks at the oscillator rate times (dividend+1)/(divisor+1). A ratio that is not a whole number, such as 19.2 MHz to 1 MHz, is therefore exact over the long run and is not rounded to a nearby integer divide. The oscillator is the only clock.

A small register port with address, write strobe, read strobe, write data and read data reaches two registers: a rate setting and the read-only microsecond count. The tick generator is a two-state machine. `GEN_FRAC` is the fractional state: each clock it adds (dividend+1) to an accumulator, and when the sum reaches (divisor+1) it subtracts that amount and emits a tick. `GEN_SAT` is the saturated state, used when the ratio is one or more: it ticks on every clock and holds the accumulator at zero. The only transition is taken on a rate write. The machine moves to `GEN_SAT` when the new dividend field is at least the new divisor field, and to `GEN_FRAC` otherwise. Reset enters `GEN_SAT`, because the reset rate setting of zero means one tick per clock.

Top module: `usec_timer`

## Requirements
- R1: Reset is a synchronous, active-high input. It clears the rate setting, the accumulator and the counter to zero, and it leaves the tick generator in the saturated state.
- R2: The counter is read at byte address 0x10 and the rate setting at 0x14. Read data is registered. It appears after the clock edge that ends the read-strobe cycle, and it holds until the next read. A counter read returns the count as it stood during the strobe cycle. Any other address reads zero.
- R3: In the rate setting, bits [15:8] hold the dividend minus one and bits [7:0] hold the divisor minus one. Bits [31:16] read as zero and ignore writes.
- R4: When the dividend field is less than the divisor field, the count N clocks after a rate write has risen by floor(N*(dividend+1)/(divisor+1)). For example, 0x000B counts once per 12 clocks and 0x045F counts 5 times per 96 clocks.
- R5: When the dividend field is greater than or equal to the divisor field, including a setting of 0, the block ticks on every clock and drops the excess.
- R6: A rate write clears the accumulator and suppresses the tick in its own cycle. It leaves the counter value unchanged.
- R7: A write to the counter address, or to any other address except 0x14, changes neither the counter nor the rate setting.
- R8: The counter is CNT_W bits wide (32 by default) and wraps from all ones to zero.
- R9: `tick_o` is high for exactly the clocks in which the counter advances, and each tick advances the counter by exactly one.
- R10: A read and a write of the rate setting in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_o | output | 1 | One-clock tick pulse |

## Verification
The rate path is tried with the four standard oscillator settings, with a non-integer fraction of 3/4, and with three saturating settings: zero, equal fields and a dividend larger than the divisor. Each setting runs for a span of clocks whose expected tick count is a floor that separates exact fractional accumulation from integer rounding and from dropped or doubled ticks. Separate directed patterns follow. An early rewrite tells a cleared accumulator from a kept one, and a rate write with a count already built up tells a preserved counter from a reset one. The direct tick sequence at ratio 1/2 tells a one-clock pulse from a stuck level. A narrow second instance tells wrapping from saturating.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;

    localparam int DATA_W     = 32;
    localparam int FIELD_W    = 8;
    localparam int CNT_OFFSET = 'h10;
    localparam int CFG_OFFSET = 'h14;

    typedef struct packed {
        logic [FIELD_W-1:0] dividend;
        logic [FIELD_W-1:0] divisor;
    } rate_cfg_t;

    typedef enum logic {
        GEN_FRAC = 1'b0,
        GEN_SAT  = 1'b1
    } gen_state_t;

endpackage

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
    import usec_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  rate_cfg_t new_cfg,
    input  rate_cfg_t cur_cfg,
    output logic      tick
);

    localparam int AW = FIELD_W + 1;

    gen_state_t      state_q, state_d;
    logic [AW-1:0]   acc_q, acc_d;
    logic [AW-1:0]   step;
    logic [AW-1:0]   modulus;
    logic [AW-1:0]   sum;
    logic            reach;

    assign step    = AW'(cur_cfg.dividend) + AW'(1);
    assign modulus = AW'(cur_cfg.divisor) + AW'(1);
    assign sum     = acc_q + step;
    assign reach   = (sum >= modulus);

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = (new_cfg.dividend >= new_cfg.divisor) ? GEN_SAT : GEN_FRAC;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_SAT;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    always_comb begin
        tick  = 1'b0;
        acc_d = '0;
        unique case (state_q)
            GEN_FRAC: begin
                if (load) begin
                    acc_d = '0;
                end else if (reach) begin
                    tick  = 1'b1;
                    acc_d = sum - modulus;
                end else begin
                    acc_d = sum;
                end
            end
            GEN_SAT: begin
                tick  = !load;
                acc_d = '0;
            end
        endcase
    end

    // R6: no tick in a rate-write cycle
    a_r6_no_tick_on_load: assert property (@(posedge clk) disable iff (rst)
        load |-> !tick);

    // R6: accumulator restarts from zero after a rate write
    a_r6_acc_cleared: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc_q == '0));

    // R4: residue stays below the modulus
    a_r4_acc_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEN_FRAC) |-> (acc_q < modulus));

    // R5: saturated mode ticks whenever no write is in progress
    a_r5_sat_every_clock: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEN_SAT && !load) |-> tick);

endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (advance) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/usec_reg_port.sv
module usec_reg_port
    import usec_timer_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [15:0]       wdata,
    input  logic [DATA_W-1:0] count_ext,
    output logic [DATA_W-1:0] rdata,
    output logic              load,
    output rate_cfg_t         new_cfg,
    output rate_cfg_t         cfg_q
);

    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(CFG_OFFSET);
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(CNT_OFFSET);

    logic [DATA_W-1:0] rd_mux;

    assign load    = wr && (addr == CFG_ADDR);
    assign new_cfg = rate_cfg_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= new_cfg;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == CNT_ADDR) begin
            rd_mux = count_ext;
        end else if (addr == CFG_ADDR) begin
            rd_mux[15:0] = cfg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_mux;
        end
    end

    // R3: upper half of the rate setting reads zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == CFG_ADDR) |=> (rdata[DATA_W-1:16] == '0));

    // R7: writes elsewhere leave the rate setting alone
    a_r7_cfg_kept: assert property (@(posedge clk) disable iff (rst)
        (wr && addr != CFG_ADDR) |=> $stable(cfg_q));

    // R2: read data holds between reads
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_timer_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              tick_o
);

    logic              load;
    rate_cfg_t         new_cfg;
    rate_cfg_t         cfg_q;
    logic              tick;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] count_ext;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:16];

    always_comb begin
        count_ext = '0;
        count_ext[CNT_W-1:0] = count;
    end

    usec_reg_port #(.ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata[15:0]),
        .count_ext (count_ext),
        .rdata     (bus_rdata),
        .load      (load),
        .new_cfg   (new_cfg),
        .cfg_q     (cfg_q)
    );

    usec_tick_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .new_cfg (new_cfg),
        .cur_cfg (cfg_q),
        .tick    (tick)
    );

    usec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .advance (tick),
        .count   (count)
    );

    assign tick_o = tick;

    // R9: each tick advances the count by exactly one, with wrap (R8)
    a_r9_step_one: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count == CNT_W'($past(count) + CNT_W'(1))));

    // R9: no tick, no change (covers R6 counter preservation)
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

endmodule

// File: tb/usec_timer_test.sv
`timescale 1ns/1ps
module usec_timer_test;

    typedef struct packed {
        logic [15:0] cfg;
        logic [15:0] cycles;
        logic [31:0] expect_cnt;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'h000B, 16'd100,  32'd8},
        '{16'h000C, 16'd130,  32'd10},
        '{16'h045F, 16'd1000, 32'd52},
        '{16'h0019, 16'd260,  32'd10},
        '{16'h0203, 16'd20,   32'd15},
        '{16'h0000, 16'd50,   32'd50},
        '{16'h0302, 16'd40,   32'd40},
        '{16'h0505, 16'd33,   32'd33}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [31:0] rdata8;
    logic        tick;
    logic        tick8;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    usec_timer uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata), .tick_o(tick)
    );

    usec_timer #(.CNT_W(8)) uut_w8 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wdata), .bus_rdata(rdata8), .tick_o(tick8)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr = 1'b0; rd = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;

        // R1, R2: reset state seen through reads
        do_reset();
        bus_read(8'h10, v);
        check("R1 counter after reset", v, 32'h0);
        bus_read(8'h14, v);
        check("R1 config after reset", v, 32'h0);

        // R4, R5: vector table
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            bus_write(8'h14, {16'h0, VECS[i].cfg});
            idle(int'(VECS[i].cycles));
            bus_read(8'h10, v);
            if (VECS[i].cfg[15:8] >= VECS[i].cfg[7:0])
                check($sformatf("R5 vector %0d", i), v, VECS[i].expect_cnt);
            else
                check($sformatf("R4 vector %0d", i), v, VECS[i].expect_cnt);
        end

        // R3: upper bits dropped
        do_reset();
        bus_write(8'h14, 32'hFFFF_ABCD);
        bus_read(8'h14, v);
        check("R3 config readback", v, 32'h0000_ABCD);

        // R2: unmapped address reads zero
        bus_read(8'h18, v);
        check("R2 unmapped read", v, 32'h0);

        // R7: write to counter address ignored
        do_reset();
        bus_write(8'h14, 32'h0);
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, v);
        check("R7 counter unaffected", v, 32'd1);
        bus_write(8'h18, 32'h0000_0B0B);
        bus_read(8'h14, v);
        check("R7 config unaffected", v, 32'h0);

        // R6: rate write keeps the count
        do_reset();
        bus_write(8'h14, 32'h0);
        idle(9);
        bus_write(8'h14, 32'h000B);
        idle(24);
        bus_read(8'h10, v);
        check("R6 count preserved", v, 32'd11);

        // R6: rate write clears the accumulator
        do_reset();
        bus_write(8'h14, 32'h000B);
        idle(11);
        bus_write(8'h14, 32'h000B);
        idle(11);
        bus_read(8'h10, v);
        check("R6 accumulator cleared", v, 32'd0);

        // R9: tick pulse pattern at ratio 1/2
        do_reset();
        bus_write(8'h14, 32'h0001);
        check("R9 tick 0", {31'h0, tick}, 32'd0);
        @(negedge clk);
        check("R9 tick 1", {31'h0, tick}, 32'd1);
        @(negedge clk);
        check("R9 tick 2", {31'h0, tick}, 32'd0);
        @(negedge clk);
        check("R9 tick 3", {31'h0, tick}, 32'd1);

        // R10: read and write of the rate setting together
        do_reset();
        bus_write(8'h14, 32'h000B);
        rd = 1'b1; wr = 1'b1; addr = 8'h14; wdata = 32'h0019;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        check("R10 old value returned", rdata, 32'h000B);
        bus_read(8'h14, v);
        check("R10 new value stored", v, 32'h0019);

        // R8: wrap on the narrow instance
        do_reset();
        bus_write(8'h14, 32'h0);
        idle(300);
        rd = 1'b1; addr = 8'h10;
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
        check("R8 narrow counter wraps", rdata8, 32'd44);
        check("R8 wide counter no wrap", rdata, 32'd300);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule